// File: doc/BRIEF.md
# Line-Lock Detector with Status

This block watches a line-locked pixel-clock PLL and reports whether the loop holds lock. On every pixel clock it samples the phase comparator's correction output. Across each video line it adds up, in pixel clocks, how long that output was active. When the once-per-line strobe arrives, it compares the total with a programmable pixel-count threshold, and so judges the line good or bad. The comparator output is used as it comes, so the noise gate and the phase limiter have already shaped the time that is measured.

From this per-line result the block keeps two status bits. The first is a sticky "no error since armed" flag, which software sets with a command write and which any bad line clears. The second is a "lock lost" flag. A single bad line raises it. It falls only after a programmable run of consecutive good lines. From the lock-lost flag and two configuration bits the block drives the phase-limit enable. In automatic mode, limiting applies only while the loop is locked, so the loop can reacquire freely.

Top module: `lineLockMonitor`

## Requirements
- R1: While reset is asserted and after it is released, errSticky is 0, lockLost is 1, and the per-line and good-run counts start from zero.
- R2: The line time is the number of clock cycles with phaseActive high, counted from the cycle after the previous lineStrobe up to and including the strobe cycle. A line is good when that time is less than or equal to pixThresh; a time exactly equal to pixThresh is good.
- R3: On a bad line, errSticky reads 0 in the cycle after the strobe. A good line leaves errSticky unchanged.
- R4: A cycle with armWr high sets errSticky to 1 from the next cycle on. If a bad-line strobe falls in the same cycle, errSticky goes to 0 instead.
- R5: On a bad line, lockLost reads 1 from the cycle after the strobe, and the run of consecutive good lines starts again from zero.
- R6: lockLost falls to 0 in the cycle after the strobe of the Nth consecutive good line, where N is lineCount, or 1 when lineCount is 0. It stays 0 on further good lines.
- R7: lockLost changes only in the cycle after a lineStrobe. errSticky changes only in the cycle after a lineStrobe or an armWr.
- R8: phaseLimitOn is 0 when limitEnable is 0. It is 1 when limitEnable is 1 and limitAuto is 0. When both are 1, it equals the inverse of lockLost.
- R9: The line-time count saturates at 2^(PIX_W+1)-1 and never wraps. With PIX_W=4, a line with 35 active cycles is bad against a threshold of 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStrobe | input | 1 | One-cycle pulse that ends each line and triggers evaluation |
| phaseActive | input | 1 | Phase comparator correction output, high while correcting |
| pixThresh | input | PIX_W (4) | Largest line time, in pixel clocks, that still counts as good |
| lineCount | input | LINE_W (8) | Consecutive good lines needed for lock |
| armWr | input | 1 | Host command strobe that sets errSticky to 1 |
| limitEnable | input | 1 | Phase-limit enable configuration bit |
| limitAuto | input | 1 | 1 = lock status gates limiting; 0 = lock status is overridden |
| errSticky | output | 1 | Sticky flag, 1 while no bad line has occurred since arming |
| lockLost | output | 1 | 1 = not continuously locked, 0 = locked |
| phaseLimitOn | output | 1 | Enable for the phase-limit circuit |

## Verification
A wrong line-time count shows up at the end of the line, on the strobe. lockLost or errSticky then takes the wrong value one cycle after it. A bad good-run count shows up as lockLost falling one line too early or too late. In automatic mode, phaseLimitOn follows lockLost, so the same faults reach it in the same cycle. Comparing every output on every clock against a reference model catches each of these in the first cycle where it is visible.

// File: rtl/lineLockPkg.sv
package lineLockPkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic clrActive;  // restart the per-line active-time count
    logic incRun;     // extend the consecutive good-line run
    logic clrRun;     // restart the consecutive good-line run
  } dpStrobe_t;

endpackage

// File: rtl/llmDatapath.sv
module llmDatapath
  import lineLockPkg::*;
#(
  parameter int PIX_W  = 4,
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseActive,
  input  logic [PIX_W-1:0]  pixThresh,
  input  logic [LINE_W-1:0] lineCount,
  input  dpStrobe_t         strb,
  output logic              lineGood,
  output logic              runDone
);

  localparam int CNT_W = PIX_W + 1;

  logic [CNT_W-1:0]  activeCnt;
  logic [CNT_W:0]    activeSum;
  logic [CNT_W-1:0]  lineTime;
  logic [LINE_W-1:0] goodRun;
  logic [LINE_W:0]   runNext;

  // Saturating accumulation of comparator-active cycles
  assign activeSum = {1'b0, activeCnt} + {{CNT_W{1'b0}}, phaseActive};
  assign lineTime  = activeSum[CNT_W] ? {CNT_W{1'b1}} : activeSum[CNT_W-1:0];
  assign lineGood  = lineTime <= {1'b0, pixThresh};

  always_ff @(posedge clk) begin
    if (!rstN)               activeCnt <= '0;
    else if (strb.clrActive) activeCnt <= '0;
    else                     activeCnt <= lineTime;
  end

  // Consecutive good-line run, saturating at the programmed count
  assign runNext = {1'b0, goodRun} + 1'b1;
  assign runDone = runNext >= {1'b0, lineCount};

  always_ff @(posedge clk) begin
    if (!rstN)            goodRun <= '0;
    else if (strb.clrRun) goodRun <= '0;
    else if (strb.incRun && (goodRun < lineCount))
                          goodRun <= runNext[LINE_W-1:0];
  end

endmodule

// File: rtl/llmControl.sv
module llmControl
  import lineLockPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineStrobe,
  input  logic      armWr,
  input  logic      lineGood,
  input  logic      runDone,
  input  logic      limitEnable,
  input  logic      limitAuto,
  output dpStrobe_t strb,
  output logic      errSticky,
  output logic      lockLost,
  output logic      phaseLimitOn
);

  logic badLine;
  logic goodLine;

  assign badLine  = lineStrobe & ~lineGood;
  assign goodLine = lineStrobe & lineGood;

  always_comb begin
    strb.clrActive = lineStrobe;
    strb.incRun    = goodLine;
    strb.clrRun    = badLine;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        errSticky <= 1'b0;
    else if (badLine) errSticky <= 1'b0;
    else if (armWr)   errSticky <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    lockLost <= 1'b1;
    else if (badLine)             lockLost <= 1'b1;
    else if (goodLine && runDone) lockLost <= 1'b0;
  end

  assign phaseLimitOn = limitEnable & (~limitAuto | ~lockLost);

endmodule

// File: rtl/lineLockMonitor.sv
module lineLockMonitor
  import lineLockPkg::*;
#(
  parameter int PIX_W  = 4,
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStrobe,
  input  logic              phaseActive,
  input  logic [PIX_W-1:0]  pixThresh,
  input  logic [LINE_W-1:0] lineCount,
  input  logic              armWr,
  input  logic              limitEnable,
  input  logic              limitAuto,
  output logic              errSticky,
  output logic              lockLost,
  output logic              phaseLimitOn
);

  dpStrobe_t strb;
  logic      lineGood;
  logic      runDone;

  llmDatapath #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .phaseActive(phaseActive),
    .pixThresh(pixThresh), .lineCount(lineCount), .strb(strb),
    .lineGood(lineGood), .runDone(runDone)
  );

  llmControl u_ctl (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .armWr(armWr),
    .lineGood(lineGood), .runDone(runDone),
    .limitEnable(limitEnable), .limitAuto(limitAuto), .strb(strb),
    .errSticky(errSticky), .lockLost(lockLost), .phaseLimitOn(phaseLimitOn)
  );

endmodule

// File: rtl/llmChecker.sv
module llmChecker (
  input logic clk,
  input logic rstN,
  input logic lineStrobe,
  input logic armWr,
  input logic lineGood,
  input logic limitEnable,
  input logic limitAuto,
  input logic errSticky,
  input logic lockLost,
  input logic phaseLimitOn
);

  a_r3_bad_clears_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && !lineGood) |=> !errSticky);

  a_r4_arm_sets_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (armWr && !(lineStrobe && !lineGood)) |=> errSticky);

  a_r5_bad_sets_lost: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && !lineGood) |=> lockLost);

  a_r6_lock_needs_good_line: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockLost) |-> $past(lineStrobe && lineGood));

  a_r7_lost_only_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !lineStrobe |=> $stable(lockLost));

  a_r7_sticky_rise_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errSticky) |-> $past(armWr));

  a_r8_forced_limit: assert property (@(posedge clk) disable iff (!rstN)
    (limitEnable && !limitAuto) |-> phaseLimitOn);

  a_r8_disabled_limit: assert property (@(posedge clk) disable iff (!rstN)
    !limitEnable |-> !phaseLimitOn);

endmodule

bind lineLockMonitor llmChecker u_llmChecker (
  .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .armWr(armWr),
  .lineGood(lineGood), .limitEnable(limitEnable), .limitAuto(limitAuto),
  .errSticky(errSticky), .lockLost(lockLost), .phaseLimitOn(phaseLimitOn)
);

// File: tb/lineLockMonitor_bench.sv
`timescale 1ns/1ps
module lineLockMonitor_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStrobe = 1'b0;
  logic       phaseActive = 1'b0;
  logic [3:0] pixThresh = 4'd5;
  logic [7:0] lineCount = 8'd3;
  logic       armWr = 1'b0;
  logic       limitEnable = 1'b1;
  logic       limitAuto = 1'b1;
  logic       errSticky, lockLost, phaseLimitOn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lineLockMonitor u_lineLockMonitor (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .phaseActive(phaseActive),
    .pixThresh(pixThresh), .lineCount(lineCount), .armWr(armWr),
    .limitEnable(limitEnable), .limitAuto(limitAuto),
    .errSticky(errSticky), .lockLost(lockLost), .phaseLimitOn(phaseLimitOn)
  );

  // Behavioural reference model
  int mActive = 0;
  int mRun = 0;
  bit mErr = 0;
  bit mLost = 1;

  always @(posedge clk) begin
    int lt;
    int need;
    bit good;
    if (!rstN) begin
      mActive = 0; mRun = 0; mErr = 0; mLost = 1;
    end else begin
      lt = mActive + (phaseActive ? 1 : 0);
      if (lt > 31) lt = 31;
      good = (lt <= int'(pixThresh));
      if (lineStrobe) begin
        mActive = 0;
        if (!good) begin
          mErr = 0; mRun = 0; mLost = 1;
        end else begin
          mRun++;
          need = (lineCount == 0) ? 1 : int'(lineCount);
          if (mRun >= need) mLost = 0;
          if (armWr) mErr = 1;
        end
      end else begin
        mActive = lt;
        if (armWr) mErr = 1;
      end
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3 R4", "errSticky", errSticky, mErr);
      check("R5 R6 R7", "lockLost", lockLost, mLost);
      check("R8", "phaseLimitOn", phaseLimitOn,
            limitEnable & (~limitAuto | ~mLost));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      lineStrobe = 0; phaseActive = 0; armWr = 0;
    end
  endtask

  // One line: nAct active cycles, then idle, strobe in the last cycle
  task automatic line(int nAct, int len, bit armAtStrobe = 0);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); #1;
      phaseActive = (i < nAct);
      lineStrobe  = (i == len - 1);
      armWr       = armAtStrobe && (i == len - 1);
    end
    @(negedge clk); #1;
    lineStrobe = 0; phaseActive = 0; armWr = 0;
  endtask

  task automatic arm();
    @(negedge clk); #1; armWr = 1;
    @(negedge clk); #1; armWr = 0;
  endtask

  initial begin
    idle(3);
    // R1: reset state
    check("R1", "errSticky in reset", errSticky, 1'b0);
    check("R1", "lockLost in reset", lockLost, 1'b1);
    @(negedge clk); #1; rstN = 1;
    idle(2);
    check("R1", "errSticky after reset", errSticky, 1'b0);
    check("R1", "lockLost after reset", lockLost, 1'b1);

    arm();
    check("R4", "errSticky armed", errSticky, 1'b1);

    // R2: time equal to threshold is good; three needed for lock
    line(5, 12);
    line(5, 12);
    check("R6", "lockLost after 2 good lines", lockLost, 1'b1);
    line(5, 12);
    check("R2 R6", "lockLost after 3 good lines", lockLost, 1'b0);
    check("R3", "errSticky kept on good lines", errSticky, 1'b1);
    check("R8", "auto limit while locked", phaseLimitOn, 1'b1);
    line(2, 10);
    check("R6", "lock held on further good line", lockLost, 1'b0);

    // R5: one bad line drops lock and clears sticky
    line(6, 12);
    check("R5", "lockLost after bad line", lockLost, 1'b1);
    check("R3", "errSticky after bad line", errSticky, 1'b0);
    check("R8", "auto limit while unlocked", phaseLimitOn, 1'b0);

    // Run restarts after a bad line
    line(0, 8); line(0, 8); line(9, 12); line(0, 8); line(0, 8);
    check("R5", "run restarted by bad line", lockLost, 1'b1);
    line(0, 8);
    check("R6", "lock after fresh run", lockLost, 1'b0);

    // R4: arm together with bad-line strobe, bad line wins
    line(8, 12, 1);
    check("R4", "bad line beats arm", errSticky, 1'b0);
    line(1, 8, 1);
    check("R4", "arm on good-line strobe", errSticky, 1'b1);

    // R6: line count zero locks after first good line
    lineCount = 8'd0;
    line(0, 6);
    check("R6", "zero count lock", lockLost, 1'b0);

    // R9: saturation, 35 active cycles against 15
    pixThresh = 4'd15;
    line(35, 40);
    check("R9", "saturated line is bad", lockLost, 1'b1);
    line(15, 20);
    check("R2", "15 of 15 is good", lockLost, 1'b0);

    // R8: mode combinations
    lineCount = 8'd2;
    line(20, 24);
    idle(1);
    limitEnable = 0;
    idle(1);
    check("R8", "disabled never limits", phaseLimitOn, 1'b0);
    limitEnable = 1; limitAuto = 0;
    idle(1);
    check("R8", "override always limits", phaseLimitOn, 1'b1);
    limitAuto = 1;
    idle(1);
    check("R8", "auto unlocked no limit", phaseLimitOn, 1'b0);

    // Mixed pattern
    pixThresh = 4'd4; lineCount = 8'd4;
    arm();
    for (int k = 0; k < 30; k++) line((k * 7) % 9, 10 + (k % 5), (k % 6) == 0);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule